// File: doc/BRIEF.md
# Stack Push/Pop Single-Cycle Datapath

This block is a single-cycle execution slice. Besides ordinary register adds it runs two stack instructions. A push lowers the stack pointer by one word and stores a register at the new top. A pop reads the word at the current top into a destination register and raises the stack pointer by one word.

Every instruction completes on the clock edge that follows its presentation. The block is driven by already-decoded control: an operation code, three register indices, an immediate selector and a 12-bit immediate field.

The slice holds four parts:
- a 32-entry register file with two write ports;
- an immediate generator;
- an adder/subtractor ALU;
- a small word memory with synchronous write and combinational read.

The stack pointer is register x2. For push and pop it is always read through the first read port.

A pop has two demands. Its memory address must come from that read port rather than from the ALU, so an address multiplexer sits in front of the memory. The loaded word and the incremented pointer land on the same edge, so the second write port carries the loaded word.

Two observation ports give combinational views of one register and one memory word. They are the only outputs and serve to inspect the state.

Top module: `stack_dp`

## Requirements
- R1: After reset, every register reads zero except x2, which reads DEPTH*4 (256 by default), and every memory word reads zero.
- R2: Operation code 1 (add) writes rs1+rs2 into rd. Operation code 2 (add immediate) writes rs1+imm into rd. The immediate depends on the selector:
  - selector 0 gives the 12-bit field sign-extended;
  - selector 7 gives the constant 4 whatever the field holds;
  - selectors 1 to 6 give zero.
- R3: Operation code 3 (push) writes x2-4 into x2. In the same cycle it stores the value of rs2 into the memory word addressed by x2-4. Push with rs2 = x2 is undefined.
- R4: Operation code 4 (pop) loads the memory word addressed by the old x2 into rd and writes x2+4 into x2, both on one edge. Pop with rd = x2 is undefined.
- R5: A sequence of pushes followed by pops returns the pushed values in reverse order and restores x2 to its starting value.
- R6: A write to x0 through either write port is discarded and x0 always reads zero. A pop into x0 still advances x2 by 4.
- R7: Operation code 0 and the unused codes 5, 6 and 7 change no register and no memory word.
- R8: A memory word is selected by byte-address bits [AW+1:2], with AW = log2(DEPTH). Higher bits are ignored, so a push from x2 = 0 writes word DEPTH-1 and leaves x2 = 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 add, 2 add immediate, 3 push, 4 pop, 5-7 none |
| rd_i | input | 5 | Destination register index |
| rs1_i | input | 5 | First source index (ignored by push and pop) |
| rs2_i | input | 5 | Second source index; push stores this register |
| imm_sel_i | input | 3 | Immediate selector for add immediate |
| imm12_i | input | 12 | Raw immediate field |
| obs_reg_i | input | 5 | Register index to observe |
| obs_reg_o | output | 32 | Value of the observed register |
| obs_word_i | input | AW | Memory word index to observe |
| obs_word_o | output | 32 | Value of the observed memory word |

## Verification
Every architectural effect of an instruction — register writes on both ports, the stack pointer change and the memory store — is due on the single rising edge after the instruction is presented. The observation outputs are combinational views of that state, so they show the result as soon as the edge has passed. The bench drives each instruction at a falling edge and lets exactly one rising edge pass. It then returns the controls to "no operation", sets the observation indices and samples a nanosecond later, well before the next rising edge. No check can therefore see a value from one edge early or one edge late.

// File: rtl/stack_dp_pkg.sv
`timescale 1ns/1ps
package stack_dp_pkg;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_ADDI  = 3'd2,
        OPC_PUSH  = 3'd3,
        OPC_POP   = 3'd4
    } opc_e;

    localparam int unsigned SP_IDX      = 2;
    localparam logic [2:0]  SEL_SEXT12  = 3'd0;
    localparam logic [2:0]  SEL_FOUR    = 3'd7;

endpackage

// File: rtl/sdp_immgen.sv
`timescale 1ns/1ps
module sdp_immgen #(
    parameter int XLEN = 32,
    parameter int IMMW = 12
) (
    input  logic [2:0]      sel_i,
    input  logic [IMMW-1:0] raw_i,
    output logic [XLEN-1:0] imm_o
);
    import stack_dp_pkg::*;

    localparam int EXTW = XLEN - IMMW;

    always_comb begin
        unique case (sel_i)
            SEL_SEXT12: imm_o = {{EXTW{raw_i[IMMW-1]}}, raw_i};
            SEL_FOUR:   imm_o = XLEN'(4);
            default:    imm_o = '0;
        endcase
    end

endmodule

// File: rtl/sdp_alu.sv
`timescale 1ns/1ps
module sdp_alu #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] y_o
);
    always_comb begin
        y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
    end

endmodule

// File: rtl/sdp_regfile.sv
`timescale 1ns/1ps
module sdp_regfile #(
    parameter int XLEN    = 32,
    parameter int NREG    = 32,
    parameter int SP_INIT = 256,
    localparam int IW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   ra1_i,
    input  logic [IW-1:0]   ra2_i,
    input  logic [IW-1:0]   ra3_i,
    output logic [XLEN-1:0] rd1_o,
    output logic [XLEN-1:0] rd2_o,
    output logic [XLEN-1:0] rd3_o,
    output logic [XLEN-1:0] sp_o,
    input  logic            we_a_i,
    input  logic [IW-1:0]   wa_a_i,
    input  logic [XLEN-1:0] wd_a_i,
    input  logic            we_b_i,
    input  logic [IW-1:0]   wa_b_i,
    input  logic [XLEN-1:0] wd_b_i
);
    import stack_dp_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_a_i && (wa_a_i != '0)) begin
            st_d.regs[wa_a_i] = wd_a_i;
        end
        if (we_b_i && (wa_b_i != '0)) begin
            st_d.regs[wa_b_i] = wd_b_i;
        end
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                st_q.regs[i] <= (i == SP_IDX) ? XLEN'(SP_INIT) : '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd1_o = st_q.regs[ra1_i];
    assign rd2_o = st_q.regs[ra2_i];
    assign rd3_o = st_q.regs[ra3_i];
    assign sp_o  = st_q.regs[SP_IDX];

    // R6: register zero never holds anything but zero
    p_x0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[0] == '0);

    // R4: both write ports land on the same edge when they target distinct registers
    p_dual_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a_i && we_b_i && wa_a_i != wa_b_i && wa_a_i != '0 && wa_b_i != '0)
        |=> (st_q.regs[$past(wa_a_i)] == $past(wd_a_i))
            && (st_q.regs[$past(wa_b_i)] == $past(wd_b_i)));

endmodule

// File: rtl/sdp_dmem.sv
`timescale 1ns/1ps
module sdp_dmem #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] addr_i,
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] rdata_o,
    input  logic [AW-1:0]   obs_i,
    output logic [XLEN-1:0] obs_o
);
    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] words;
    } mem_state_t;

    mem_state_t st_d, st_q;
    logic [AW-1:0] widx;

    assign widx = addr_i[AW+1:2];

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.words[widx] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.words[widx];
    assign obs_o   = st_q.words[obs_i];

    // R3: a store is visible at its word on the following cycle
    p_store_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> st_q.words[$past(widx)] == $past(wdata_i));

endmodule

// File: rtl/stack_dp.sv
`timescale 1ns/1ps
module stack_dp #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int DEPTH = 64,
    parameter int IMMW  = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [IW-1:0]   rd_i,
    input  logic [IW-1:0]   rs1_i,
    input  logic [IW-1:0]   rs2_i,
    input  logic [2:0]      imm_sel_i,
    input  logic [IMMW-1:0] imm12_i,
    input  logic [IW-1:0]   obs_reg_i,
    output logic [XLEN-1:0] obs_reg_o,
    input  logic [AW-1:0]   obs_word_i,
    output logic [XLEN-1:0] obs_word_o
);
    import stack_dp_pkg::*;

    localparam int SP_INIT = DEPTH * 4;

    logic            is_add, is_addi, is_push, is_pop, is_stack;
    logic [IW-1:0]   ra1;
    logic [2:0]      sel_eff;
    logic [XLEN-1:0] rd1, rd2, sp_val, imm, alu_b, alu_y;
    logic [XLEN-1:0] mem_addr, ld_data;
    logic            we_a;
    logic [IW-1:0]   wa_a;

    always_comb begin
        is_add   = (op_i == OPC_ADD);
        is_addi  = (op_i == OPC_ADDI);
        is_push  = (op_i == OPC_PUSH);
        is_pop   = (op_i == OPC_POP);
        is_stack = is_push | is_pop;
        ra1      = is_stack ? IW'(SP_IDX) : rs1_i;
        sel_eff  = is_stack ? SEL_FOUR : imm_sel_i;
        alu_b    = is_add ? rd2 : imm;
        mem_addr = is_pop ? rd1 : alu_y;
        we_a     = is_add | is_addi | is_stack;
        wa_a     = is_stack ? IW'(SP_IDX) : rd_i;
    end

    sdp_immgen #(.XLEN(XLEN), .IMMW(IMMW)) u_imm (
        .sel_i (sel_eff),
        .raw_i (imm12_i),
        .imm_o (imm)
    );

    sdp_alu #(.XLEN(XLEN)) u_alu (
        .a_i   (rd1),
        .b_i   (alu_b),
        .sub_i (is_push),
        .y_o   (alu_y)
    );

    sdp_regfile #(.XLEN(XLEN), .NREG(NREG), .SP_INIT(SP_INIT)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra1_i  (ra1),
        .ra2_i  (rs2_i),
        .ra3_i  (obs_reg_i),
        .rd1_o  (rd1),
        .rd2_o  (rd2),
        .rd3_o  (obs_reg_o),
        .sp_o   (sp_val),
        .we_a_i (we_a),
        .wa_a_i (wa_a),
        .wd_a_i (alu_y),
        .we_b_i (is_pop),
        .wa_b_i (rd_i),
        .wd_b_i (ld_data)
    );

    sdp_dmem #(.XLEN(XLEN), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (mem_addr),
        .we_i    (is_push),
        .wdata_i (rd2),
        .rdata_o (ld_data),
        .obs_i   (obs_word_i),
        .obs_o   (obs_word_o)
    );

    // R2: push and pop always see the constant-four immediate
    p_stack_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_stack |-> imm == XLEN'(4));

    // R3: push lowers the stack pointer by one word
    p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && rs2_i != IW'(SP_IDX)) |=> sp_val == $past(sp_val) - XLEN'(4));

    // R4: pop raises the stack pointer by one word
    p_pop_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && rd_i != IW'(SP_IDX)) |=> sp_val == $past(sp_val) + XLEN'(4));

    // R4: the pop address is the pointer value from before the update
    p_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_pop |-> mem_addr == sp_val);

    // R7: operations without a write leave the stack pointer alone
    p_idle_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_add && !is_addi && !is_stack) |=> $stable(sp_val));

endmodule

// File: tb/stack_dp_test.sv
`timescale 1ns/1ps
module stack_dp_test;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [4:0]  rd = '0, rs1 = '0, rs2 = '0;
    logic [2:0]  sel = '0;
    logic [11:0] imm = '0;
    logic [4:0]  oreg = '0;
    logic [31:0] oreg_v;
    logic [AW-1:0] oword = '0;
    logic [31:0] oword_v;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    stack_dp #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .rd_i(rd), .rs1_i(rs1),
        .rs2_i(rs2), .imm_sel_i(sel), .imm12_i(imm), .obs_reg_i(oreg),
        .obs_reg_o(oreg_v), .obs_word_i(oword), .obs_word_o(oword_v)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [2:0]  sel;
        logic [11:0] imm;
        logic [4:0]  chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 5'd5,  5'd0, 5'd0, 3'd0, 12'd100,  5'd5,  32'd100,        4'd2}, // R2 sext
        '{3'd2, 5'd6,  5'd0, 5'd0, 3'd0, 12'hFFD,  5'd6,  32'hFFFF_FFFD,  4'd2}, // R2 negative
        '{3'd1, 5'd7,  5'd5, 5'd6, 3'd0, 12'd0,    5'd7,  32'd97,         4'd2}, // R2 add
        '{3'd2, 5'd8,  5'd5, 5'd0, 3'd7, 12'd123,  5'd8,  32'd104,        4'd2}, // R2 const four
        '{3'd2, 5'd9,  5'd5, 5'd0, 3'd3, 12'd55,   5'd9,  32'd100,        4'd2}, // R2 zero imm
        '{3'd3, 5'd0,  5'd0, 5'd5, 3'd0, 12'd0,    5'd2,  32'd252,        4'd3}, // R3 push x5
        '{3'd3, 5'd0,  5'd0, 5'd7, 3'd0, 12'd0,    5'd2,  32'd248,        4'd3}, // R3 push x7
        '{3'd4, 5'd10, 5'd0, 5'd0, 3'd0, 12'd0,    5'd10, 32'd97,         4'd5}, // R5 last in first out
        '{3'd0, 5'd0,  5'd0, 5'd0, 3'd0, 12'd0,    5'd2,  32'd252,        4'd4}, // R4 sp after pop
        '{3'd4, 5'd11, 5'd0, 5'd0, 3'd0, 12'd0,    5'd11, 32'd100,        4'd5}, // R5 first pushed
        '{3'd0, 5'd0,  5'd0, 5'd0, 3'd0, 12'd0,    5'd2,  32'd256,        4'd5}, // R5 sp restored
        '{3'd1, 5'd0,  5'd5, 5'd5, 3'd0, 12'd0,    5'd0,  32'd0,          4'd6}, // R6 add to x0
        '{3'd7, 5'd5,  5'd5, 5'd5, 3'd7, 12'd9,    5'd5,  32'd100,        4'd7}  // R7 unused code
    };

    task automatic issue(input logic [2:0] o, input logic [4:0] d, input logic [4:0] s1,
                         input logic [4:0] s2, input logic [2:0] sl, input logic [11:0] im);
        @(negedge clk);
        op = o; rd = d; rs1 = s1; rs2 = s2; sel = sl; imm = im;
        @(posedge clk);
        @(negedge clk);
        op = '0; rd = '0; rs1 = '0; rs2 = '0; sel = '0; imm = '0;
    endtask

    task automatic chk_reg(input logic [4:0] idx, input logic [31:0] exp, input string req);
        oreg = idx;
        #1;
        n_chk++;
        if (oreg_v !== exp) begin
            n_bad++;
            $display("FAIL %s x%0d actual %h expected %h", req, idx, oreg_v, exp);
        end
    endtask

    task automatic chk_word(input logic [AW-1:0] idx, input logic [31:0] exp, input string req);
        oword = idx;
        #1;
        n_chk++;
        if (oword_v !== exp) begin
            n_bad++;
            $display("FAIL %s word %0d actual %h expected %h", req, idx, oword_v, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_reg(5'd2, 32'd256, "R1");
        chk_reg(5'd5, 32'd0, "R1");
        chk_word(AW'(0), 32'd0, "R1");
        chk_word(AW'(DEPTH-1), 32'd0, "R1");

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].rd, VECS[i].rs1, VECS[i].rs2, VECS[i].sel, VECS[i].imm);
            chk_reg(VECS[i].chk, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R3 stored words remain after pops
        chk_word(AW'(63), 32'd100, "R3");
        chk_word(AW'(62), 32'd97, "R3");

        // R6 pop into x0 still moves sp; address 256 wraps to word 0 (R8)
        issue(3'd4, 5'd0, 5'd0, 5'd0, 3'd0, 12'd0);
        chk_reg(5'd2, 32'd260, "R6");
        chk_reg(5'd0, 32'd0, "R6");

        // R8 push from sp = 0 wraps to the top word
        issue(3'd2, 5'd2, 5'd0, 5'd0, 3'd0, 12'd0);
        chk_reg(5'd2, 32'd0, "R8");
        issue(3'd3, 5'd0, 5'd0, 5'd6, 3'd0, 12'd0);
        chk_reg(5'd2, 32'hFFFF_FFFC, "R8");
        chk_word(AW'(DEPTH-1), 32'hFFFF_FFFD, "R8");
        issue(3'd4, 5'd12, 5'd0, 5'd0, 3'd0, 12'd0);
        chk_reg(5'd12, 32'hFFFF_FFFD, "R4");
        chk_reg(5'd2, 32'd0, "R4");

        // R7 code 5 changes nothing, including memory
        issue(3'd5, 5'd7, 5'd5, 5'd5, 3'd0, 12'd1);
        chk_reg(5'd7, 32'd97, "R7");
        chk_word(AW'(DEPTH-1), 32'hFFFF_FFFD, "R7");

        // R1 reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_reg(5'd7, 32'd0, "R1");
        chk_reg(5'd2, 32'd256, "R1");
        chk_word(AW'(DEPTH-1), 32'd0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule